// File: doc/BRIEF.md
# Cache Error Collector

This block gathers uncorrectable cache errors from several local detection units and turns them into one exception request for the processor. Each unit owns a local record holding the cache index, the way and an error kind for the first uncorrectable error it sees. It also holds a flag that tells whether a further error hit that unit while the first one was still waiting. As long as any record is waiting and the global disable input is low, the block drives its exception request.

When the processor takes the exception, it sends a one-cycle pulse. In the cycle after that pulse, the lowest-numbered waiting unit hands its record to a central register. That unit's local record then becomes free again. The central register carries a second-error flag that only reset clears. Through it, the handler learns that at least one error report was folded into an earlier one.

The global disable input freezes local logging and masks the request. Index-type cache maintenance operations, such as tag or data reads and writes by index, make a unit ignore its detected error altogether. A per-unit hit-kill output tells the cache when an uncorrectable error must stop a hit. That output stays low under disable or maintenance, so the access completes normally.

Top module: `cerr_collector`

## Requirements
- R1: An uncorrectable error on a unit with no waiting record is captured at the next clock edge. From the cycle after the error, excReq is 1 while any record waits and disableIn is 0.
- R2: A further error on a unit that already holds a waiting record leaves the stored index, way and kind unchanged and sets that unit's local second-error flag.
- R3: An excTaken pulse sampled at edge k arms a transfer. In the cycle between edges k and k+1, the lowest waiting unit is selected. At edge k+1 its record is loaded into cerrValid=1, cerrUnit, cerrIdx, cerrWay and cerrKind, and the local record is cleared.
- R4: At a transfer, cerrEw becomes 1 if the transferred unit's local flag was set, or if that unit detects an error in the transfer cycle. Once cerrEw is 1, it stays 1 until reset.
- R5: While disableIn is 1, excReq is 0, no local record is captured and no local second-error flag is set. Records that were already waiting raise excReq again once disableIn returns to 0.
- R6: hitKill[u] is 1 exactly when errDet[u] is 1, maintOp[u] is 0 and disableIn is 0. It is combinational in the same cycle.
- R7: An error on unit u while maintOp[u] is 1 captures nothing, sets no flag and raises no request.
- R8: With several records waiting, each excTaken pulse transfers one record, lowest unit index first. excReq stays 1 until the last waiting record has been transferred.
- R9: After reset, excReq, cerrValid, cerrUnit, cerrIdx, cerrWay, cerrKind and cerrEw are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| disableIn | input | 1 | Global disable of logging and exception posting |
| excTaken | input | 1 | One-cycle pulse: the cache error exception was taken |
| errDet | input | NUM_UNITS | Per-unit uncorrectable error strobe |
| maintOp | input | NUM_UNITS | Per-unit index maintenance operation in progress |
| errIdx | input | NUM_UNITS*IDX_W | Per-unit cache index of the error |
| errWay | input | NUM_UNITS*WAY_W | Per-unit cache way of the error |
| errKind | input | NUM_UNITS*KIND_W | Per-unit error kind code |
| excReq | output | 1 | Cache error exception request |
| hitKill | output | NUM_UNITS | Per-unit hit suppression for an uncorrectable error |
| cerrValid | output | 1 | Central register holds a transferred record |
| cerrUnit | output | UNIT_W | Unit that supplied the central record |
| cerrIdx | output | IDX_W | Central record cache index |
| cerrWay | output | WAY_W | Central record cache way |
| cerrKind | output | KIND_W | Central record error kind |
| cerrEw | output | 1 | Sticky second-error flag |

## Verification
The assertions check several properties on every cycle. A local second-error flag never stands without a waiting record. The central flag never falls. A transfer only follows a taken pulse, and it always picks a waiting unit with no lower waiting unit. Under disable with no transfer, the local records never change, and a unit under maintenance never gains a record. Other behaviour needs the bench's reference model over chosen scenarios. That covers the exact record contents after a transfer, an error that lands in the transfer cycle itself, the request reappearing when disable drops, and the order across several waiting units.

// File: rtl/cerr_pkg.sv
package cerr_pkg;
  parameter int IDX_W  = 10;
  parameter int WAY_W  = 2;
  parameter int KIND_W = 3;
  parameter int UNIT_W = 3;  // addresses up to 2**UNIT_W units

  typedef struct packed {
    logic [IDX_W-1:0]  idx;
    logic [WAY_W-1:0]  way;
    logic [KIND_W-1:0] kind;
  } errRec_t;

  typedef struct packed {
    logic              xferGo;
    logic [UNIT_W-1:0] xferUnit;
  } xferStrobe_t;
endpackage

// File: rtl/cerr_ctrl.sv
module cerr_ctrl
  import cerr_pkg::*;
#(
  parameter int NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 excTaken,
  input  logic                 disableIn,
  input  logic [NUM_UNITS-1:0] localValid,
  output logic                 excReq,
  output xferStrobe_t          strobe
);
  logic armQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armQ <= 1'b0;
    else       armQ <= excTaken;
  end

  // lowest waiting unit wins: scan from the top so the lowest overwrites
  always_comb begin
    strobe = '0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (localValid[i]) strobe.xferUnit = UNIT_W'(i);
    end
    strobe.xferGo = armQ && (|localValid);
  end

  assign excReq = (|localValid) && !disableIn;

  logic [NUM_UNITS-1:0] lowerMask;
  always_comb begin
    lowerMask = '0;
    for (int i = 0; i < NUM_UNITS; i++) lowerMask[i] = (UNIT_W'(i) < strobe.xferUnit);
  end

  AST_XFER_AFTER_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.xferGo |-> $past(excTaken)); // R3
  AST_XFER_PICKS_WAITING: assert property (@(posedge clk) disable iff (!rstN)
    strobe.xferGo |-> localValid[strobe.xferUnit]); // R3
  AST_XFER_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.xferGo |-> ((localValid & lowerMask) == '0)); // R8
endmodule

// File: rtl/cerr_data.sv
module cerr_data
  import cerr_pkg::*;
#(
  parameter int NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 disableIn,
  input  logic [NUM_UNITS-1:0] errDet,
  input  logic [NUM_UNITS-1:0] maintOp,
  input  errRec_t              recIn [NUM_UNITS],
  input  xferStrobe_t          strobe,
  output logic [NUM_UNITS-1:0] localValid,
  output logic [NUM_UNITS-1:0] hitKill,
  output logic                 cerrValid,
  output logic [UNIT_W-1:0]    cerrUnit,
  output errRec_t              cerrRec,
  output logic                 cerrEw
);
  errRec_t              recQ [NUM_UNITS];
  logic [NUM_UNITS-1:0] validQ, ewQ, logErr, takeMe;

  always_comb begin
    for (int i = 0; i < NUM_UNITS; i++) begin
      logErr[i] = errDet[i] && !maintOp[i] && !disableIn;
      takeMe[i] = strobe.xferGo && (strobe.xferUnit == UNIT_W'(i));
    end
  end

  assign hitKill    = logErr;
  assign localValid = validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      ewQ    <= '0;
      for (int i = 0; i < NUM_UNITS; i++) recQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_UNITS; i++) begin
        if (takeMe[i]) begin
          validQ[i] <= 1'b0;
          ewQ[i]    <= 1'b0;
        end else if (logErr[i]) begin
          if (validQ[i]) ewQ[i] <= 1'b1;
          else begin
            validQ[i] <= 1'b1;
            recQ[i]   <= recIn[i];
          end
        end
      end
    end
  end

  errRec_t selRec;
  logic    selEw;
  always_comb begin
    selRec = '0;
    selEw  = 1'b0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (takeMe[i]) begin
        selRec = recQ[i];
        selEw  = ewQ[i] | logErr[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cerrValid <= 1'b0;
      cerrUnit  <= '0;
      cerrRec   <= '0;
      cerrEw    <= 1'b0;
    end else if (strobe.xferGo) begin
      cerrValid <= 1'b1;
      cerrUnit  <= strobe.xferUnit;
      cerrRec   <= selRec;
      cerrEw    <= cerrEw | selEw;
    end
  end

  AST_EW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cerrEw |=> cerrEw); // R4
  AST_DISABLE_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (disableIn && !strobe.xferGo) |=> ($stable(validQ) && $stable(ewQ))); // R5

  for (genvar g = 0; g < NUM_UNITS; g++) begin : gUnitChk
    AST_LOCAL_EW_NEEDS_RECORD: assert property (@(posedge clk) disable iff (!rstN)
      ewQ[g] |-> validQ[g]); // R2
    AST_MAINT_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
      (maintOp[g] && !validQ[g]) |=> !validQ[g]); // R7
  end
endmodule

// File: rtl/cerr_collector.sv
module cerr_collector
  import cerr_pkg::*;
#(
  parameter int NUM_UNITS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        disableIn,
  input  logic                        excTaken,
  input  logic [NUM_UNITS-1:0]        errDet,
  input  logic [NUM_UNITS-1:0]        maintOp,
  input  logic [NUM_UNITS*IDX_W-1:0]  errIdx,
  input  logic [NUM_UNITS*WAY_W-1:0]  errWay,
  input  logic [NUM_UNITS*KIND_W-1:0] errKind,
  output logic                        excReq,
  output logic [NUM_UNITS-1:0]        hitKill,
  output logic                        cerrValid,
  output logic [UNIT_W-1:0]           cerrUnit,
  output logic [IDX_W-1:0]            cerrIdx,
  output logic [WAY_W-1:0]            cerrWay,
  output logic [KIND_W-1:0]           cerrKind,
  output logic                        cerrEw
);
  errRec_t              recIn [NUM_UNITS];
  errRec_t              cerrRec;
  xferStrobe_t          strobe;
  logic [NUM_UNITS-1:0] localValid;

  for (genvar g = 0; g < NUM_UNITS; g++) begin : gRecIn
    assign recIn[g].idx  = errIdx[g*IDX_W +: IDX_W];
    assign recIn[g].way  = errWay[g*WAY_W +: WAY_W];
    assign recIn[g].kind = errKind[g*KIND_W +: KIND_W];
  end

  cerr_ctrl #(.NUM_UNITS(NUM_UNITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .excTaken(excTaken), .disableIn(disableIn),
    .localValid(localValid), .excReq(excReq), .strobe(strobe)
  );

  cerr_data #(.NUM_UNITS(NUM_UNITS)) u_data (
    .clk(clk), .rstN(rstN), .disableIn(disableIn), .errDet(errDet),
    .maintOp(maintOp), .recIn(recIn), .strobe(strobe),
    .localValid(localValid), .hitKill(hitKill), .cerrValid(cerrValid),
    .cerrUnit(cerrUnit), .cerrRec(cerrRec), .cerrEw(cerrEw)
  );

  assign cerrIdx  = cerrRec.idx;
  assign cerrWay  = cerrRec.way;
  assign cerrKind = cerrRec.kind;
endmodule

// File: tb/cerr_collector_bench.sv
module cerr_collector_bench;
  import cerr_pkg::*;
  localparam int NU = 4;

  logic clk = 1'b0, rstN = 1'b0, disableIn = 1'b0, excTaken = 1'b0;
  logic [NU-1:0] errDet = '0, maintOp = '0;
  logic [NU*IDX_W-1:0]  errIdx  = '0;
  logic [NU*WAY_W-1:0]  errWay  = '0;
  logic [NU*KIND_W-1:0] errKind = '0;
  logic excReq, cerrValid, cerrEw;
  logic [NU-1:0] hitKill;
  logic [UNIT_W-1:0] cerrUnit;
  logic [IDX_W-1:0] cerrIdx;
  logic [WAY_W-1:0] cerrWay;
  logic [KIND_W-1:0] cerrKind;

  cerr_collector #(.NUM_UNITS(NU)) u_cerr_collector (.*);

  always #2 clk = ~clk;  // 250 MHz

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mValid[NU], mEw[NU], mIdx[NU], mWay[NU], mKind[NU];
  int mArm, cV, cU, cI, cW, cK, cE;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mValid[u]) begin mValid[u]=0; mEw[u]=0; mIdx[u]=0; mWay[u]=0; mKind[u]=0; end
      mArm=0; cV=0; cU=0; cI=0; cW=0; cK=0; cE=0;
    end else begin
      int sel; int newE[NU];
      sel = -1;
      if (mArm != 0) for (int u = NU-1; u >= 0; u--) if (mValid[u] != 0) sel = u;
      for (int u = 0; u < NU; u++) newE[u] = (errDet[u] && !maintOp[u] && !disableIn) ? 1 : 0;
      if (sel >= 0) begin
        cV=1; cU=sel; cI=mIdx[sel]; cW=mWay[sel]; cK=mKind[sel];
        if (mEw[sel] != 0 || newE[sel] != 0) cE = 1;
        mValid[sel]=0; mEw[sel]=0;
      end
      for (int u = 0; u < NU; u++) begin
        if (u != sel && newE[u] != 0) begin
          if (mValid[u] != 0) mEw[u] = 1;
          else begin
            mValid[u]=1; mIdx[u]=int'(errIdx[u*IDX_W +: IDX_W]);
            mWay[u]=int'(errWay[u*WAY_W +: WAY_W]); mKind[u]=int'(errKind[u*KIND_W +: KIND_W]);
          end
        end
      end
      mArm = excTaken ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      int anyV; int hk;
      anyV = 0; hk = 0;
      foreach (mValid[u]) if (mValid[u] != 0) anyV = 1;
      for (int u = 0; u < NU; u++) if (errDet[u] && !maintOp[u] && !disableIn) hk |= (1 << u);
      chk("R1 excReq", int'(excReq), (anyV != 0 && !disableIn) ? 1 : 0);
      chk("R6 hitKill", int'(hitKill), hk);
      chk("R3 cerrValid", int'(cerrValid), cV);
      chk("R3 cerrUnit", int'(cerrUnit), cU);
      chk("R3 cerrIdx", int'(cerrIdx), cI);
      chk("R3 cerrWay", int'(cerrWay), cW);
      chk("R3 cerrKind", int'(cerrKind), cK);
      chk("R4 cerrEw", int'(cerrEw), cE);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic idle();
    errDet = '0; maintOp = '0; excTaken = 1'b0;
  endtask

  task automatic setErr(int u, int idx, int way, int kind);
    errDet[u] = 1'b1;
    errIdx[u*IDX_W +: IDX_W]    = IDX_W'(idx);
    errWay[u*WAY_W +: WAY_W]    = WAY_W'(way);
    errKind[u*KIND_W +: KIND_W] = KIND_W'(kind);
  endtask

  task automatic doReset();
    idle(); disableIn = 1'b0; rstN = 1'b0;
    cyc(2); rstN = 1'b1; cyc(1);
  endtask

  task automatic takePulse();
    idle(); excTaken = 1'b1; cyc(1); excTaken = 1'b0;
  endtask

  initial begin
    cyc(2); rstN = 1'b1; cyc(1);
    // R9 reset state
    chk("R9 excReq", int'(excReq), 0);
    chk("R9 cerrValid", int'(cerrValid), 0);
    chk("R9 cerrEw", int'(cerrEw), 0);
    chk("R9 cerrIdx", int'(cerrIdx), 0);

    // R4: error in the transfer cycle on the unit being transferred
    setErr(2, 300, 1, 5); cyc(1);
    takePulse();                       // armed; next cycle is the transfer cycle
    setErr(2, 12, 2, 2); cyc(1); idle(); cyc(1);
    chk("R4 ew from transfer-cycle error", int'(cerrEw), 1);
    chk("R3 unit after transfer", int'(cerrUnit), 2);
    chk("R3 idx after transfer", int'(cerrIdx), 300);
    chk("R3 local cleared", int'(excReq), 0);

    doReset();
    chk("R4 cleared only by reset", int'(cerrEw), 0);

    // R1/R2: capture, then second error keeps first record
    setErr(1, 85, 3, 1); cyc(1); idle(); cyc(1);
    chk("R1 request raised", int'(excReq), 1);
    setErr(1, 119, 0, 6); cyc(1); idle(); cyc(1);
    takePulse(); cyc(2);
    chk("R2 first idx kept", int'(cerrIdx), 85);
    chk("R2 first way kept", int'(cerrWay), 3);
    chk("R2 ew reported", int'(cerrEw), 1);

    // R8: priority across units 3 and 0
    setErr(3, 33, 1, 3); setErr(0, 44, 2, 4); cyc(1); idle(); cyc(1);
    takePulse(); cyc(2);
    chk("R8 lowest unit first", int'(cerrUnit), 0);
    chk("R8 request held", int'(excReq), 1);
    takePulse(); cyc(2);
    chk("R8 next unit", int'(cerrUnit), 3);
    chk("R8 request dropped", int'(excReq), 0);
    chk("R4 ew still set", int'(cerrEw), 1);

    // R5: disable blocks logging and posting
    disableIn = 1'b1; setErr(0, 7, 0, 0); cyc(1);
    chk("R5 no hitKill under disable", int'(hitKill), 0);
    idle(); cyc(1);
    chk("R5 no request under disable", int'(excReq), 0);
    disableIn = 1'b0; cyc(1);
    chk("R5 nothing logged", int'(excReq), 0);
    setErr(2, 9, 1, 1); cyc(1); idle(); disableIn = 1'b1; cyc(1);
    chk("R5 pending masked", int'(excReq), 0);
    disableIn = 1'b0; cyc(1);
    chk("R5 pending reappears", int'(excReq), 1);
    takePulse(); cyc(2);

    // R7: maintenance operation ignores the error
    maintOp[1] = 1'b1; setErr(1, 5, 0, 2); cyc(1);
    chk("R7 no hitKill", int'(hitKill[1]), 0);
    idle(); cyc(1);
    chk("R7 no request", int'(excReq), 0);

    // random phase against the model
    for (int n = 0; n < 400; n++) begin
      idle();
      disableIn = ($urandom_range(9) == 0);
      excTaken  = ($urandom_range(5) == 0);
      for (int u = 0; u < NU; u++) begin
        if ($urandom_range(6) == 0)
          setErr(u, int'($urandom_range(1023)), int'($urandom_range(3)), int'($urandom_range(7)));
        maintOp[u] = ($urandom_range(5) == 0);
      end
      cyc(1);
    end
    idle(); disableIn = 1'b0; cyc(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule